// File: doc/BRIEF.md
# Programmable YCbCr-to-RGB Color Converter

This block sits in the pixel path of a display plane. It accepts one pixel per clock with three 10-bit components, a valid flag and a per-pixel format flag. A pixel flagged as YCbCr goes through four steps:

1. Its chroma components are re-centred on zero.
2. All three inputs are limited to programmable windows.
3. The black level is removed from luma.
4. A programmable 3x3 signed fixed-point matrix produces full-range 10-bit RGB.

A pixel flagged as RGB is carried through unchanged.

Settings are loaded through a simple write port into a shadow copy. The shadow copy is moved into the working copy only on a frame-start strobe, so a frame never sees a mix of old and new settings. A two-state machine tracks the shadow copy:

- `CFG_SYNCED`: the shadow copy equals the working copy.
- `CFG_STAGED`: at least one write is waiting to be committed.

The state transitions are:

- Any write to a mapped address moves `CFG_SYNCED` to `CFG_STAGED`.
- A frame-start strobe with no write in the same cycle moves `CFG_STAGED` to `CFG_SYNCED`, and commits the settings.
- A write in the same cycle as a frame-start strobe commits the older shadow contents and keeps the state in `CFG_STAGED`.

The reset settings convert limited-range BT.601 YCbCr to full-range RGB.

Top module: `pix_csc_top`

## Requirements
- R1: Coefficient and window settings:
  - Coefficients are 16-bit two's complement values with 12 fractional bits, so 4096 means 1.0.
  - Write address `ch*3+k` (0..8) selects the coefficient for output channel ch (0=R, 1=G, 2=B) and input k (0=Y, 1=Cb, 2=Cr).
  - Addresses 9..13 hold 11-bit signed values taken from the low write-data bits: 9 is the luma offset, 10 and 11 are the luma low and high limits, and 12 and 13 are the chroma low and high limits.
  - Reset values are: coefficients 4769, 0, 6537 / 4769, -1605, -3330 / 4769, 8263, 0; offset 64; luma window [64, 940]; chroma window [-448, 448].
- R2: For a YCbCr pixel, 512 is subtracted from each chroma component (inputs c1=Cb, c2=Cr). The signed result is then limited to [chroma low, chroma high].
- R3: For a YCbCr pixel, luma (input c0) is limited to [luma low, luma high], and the luma offset is then subtracted.
- R4: Each YCbCr output channel equals (sum of its three coefficient x operand products + 2048) arithmetically shifted right by 12, saturated to [0, 1023].
- R5: A pixel with `in_is_rgb`=1 appears at the output unchanged (c0 to R, c1 to G, c2 to B) with `out_is_rgb`=1, whatever the settings hold.
- R6: Every pixel appears exactly 3 rising edges after the edge that captures it, counting the capturing edge. Valid and format flags follow their data, order is kept, and an idle input cycle gives an idle output cycle. `out_valid` is 0 during and right after reset.
- R7: Writes change nothing until a frame-start strobe. A pixel captured on the edge after the strobe's edge uses the new settings.
- R8: Writes to addresses 14 and 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 4 | Settings write address |
| cfg_wdata | input | 16 | Settings write data |
| frame_start | input | 1 | Frame-start strobe, commits staged settings |
| in_valid | input | 1 | Input pixel valid |
| in_is_rgb | input | 1 | 1 = RGB pixel (bypass), 0 = YCbCr |
| in_c0 | input | 10 | Y or R component |
| in_c1 | input | 10 | Cb or G component |
| in_c2 | input | 10 | Cr or B component |
| out_valid | output | 1 | Output pixel valid |
| out_is_rgb | output | 1 | Format flag of the output pixel |
| out_r | output | 10 | Red |
| out_g | output | 10 | Green |
| out_b | output | 10 | Blue |

## Verification
Each pixel is captured on a rising edge and its result is due three rising edges later, with the bypass and converted pixels on the same schedule. The bench drives pixels on falling edges. On each falling edge it first compares the output against the pixel driven three falling edges earlier, then drives the next one, so back-to-back streams with gaps are checked cycle by cycle. Settings take effect for the pixel captured one edge after the frame-start edge. For this reason each scenario issues its strobe and only then starts its stream, and it sends one pixel before the strobe to show the old settings still apply.

// File: rtl/pix_csc_pkg.sv
package pix_csc_pkg;
    parameter int DW    = 10;   // component width
    parameter int CW    = 16;   // coefficient width
    parameter int FRAC  = 12;   // coefficient fraction bits
    parameter int LW    = 11;   // window / offset register width
    parameter int NCH   = 3;    // components per pixel
    parameter int AW    = 4;    // settings address width

    localparam int NCOEF      = NCH * NCH;
    localparam int MW         = DW + 3;          // prepared operand width
    localparam int PW         = CW + MW;         // product width
    localparam int SW         = PW + 2;          // sum width
    localparam int CHROMA_MID = 1 << (DW - 1);
    localparam int PIX_MAX    = (1 << DW) - 1;
    localparam int RND        = 1 << (FRAC - 1);

    localparam logic [AW-1:0] A_YOFF = AW'(NCOEF);
    localparam logic [AW-1:0] A_YLO  = AW'(NCOEF + 1);
    localparam logic [AW-1:0] A_YHI  = AW'(NCOEF + 2);
    localparam logic [AW-1:0] A_CLO  = AW'(NCOEF + 3);
    localparam logic [AW-1:0] A_CHI  = AW'(NCOEF + 4);

    typedef enum logic {CFG_SYNCED, CFG_STAGED} cfg_state_e;

    typedef struct packed {
        logic [NCOEF-1:0][CW-1:0] coef;
        logic [LW-1:0]            y_off;
        logic [LW-1:0]            y_lo;
        logic [LW-1:0]            y_hi;
        logic [LW-1:0]            c_lo;
        logic [LW-1:0]            c_hi;
    } csc_cfg_t;

    function automatic csc_cfg_t cfg_default();
        csc_cfg_t c;
        c.coef[0] = CW'(4769);
        c.coef[1] = CW'(0);
        c.coef[2] = CW'(6537);
        c.coef[3] = CW'(4769);
        c.coef[4] = CW'(-1605);
        c.coef[5] = CW'(-3330);
        c.coef[6] = CW'(4769);
        c.coef[7] = CW'(8263);
        c.coef[8] = CW'(0);
        c.y_off   = LW'(64);
        c.y_lo    = LW'(64);
        c.y_hi    = LW'(940);
        c.c_lo    = LW'(-448);
        c.c_hi    = LW'(448);
        return c;
    endfunction

    function automatic logic signed [MW-1:0] sx(input logic [LW-1:0] v);
        return {{(MW-LW){v[LW-1]}}, v};
    endfunction

    function automatic logic signed [MW-1:0] clampv(input logic signed [MW-1:0] v,
                                                    input logic signed [MW-1:0] lo,
                                                    input logic signed [MW-1:0] hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction
endpackage

// File: rtl/pix_csc_regs.sv
module pix_csc_regs
    import pix_csc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          frame_start,
    output csc_cfg_t      act_cfg
);
    cfg_state_e state_q, state_d;
    csc_cfg_t   shadow_q, act_q;
    logic       wr_hit;
    logic       commit;

    assign wr_hit = cfg_we && (cfg_addr <= A_CHI);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_SYNCED;
        else        state_q <= state_d;
    end

    // next state and commit strobe
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            CFG_SYNCED: begin
                if (wr_hit) state_d = CFG_STAGED;
            end
            CFG_STAGED: begin
                commit = frame_start;
                if (frame_start && !wr_hit) state_d = CFG_SYNCED;
            end
            default: state_d = CFG_SYNCED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= cfg_default();
        end else if (wr_hit) begin
            for (int i = 0; i < NCOEF; i++) begin
                if (cfg_addr == AW'(i)) shadow_q.coef[i] <= cfg_wdata;
            end
            if (cfg_addr == A_YOFF) shadow_q.y_off <= cfg_wdata[LW-1:0];
            if (cfg_addr == A_YLO)  shadow_q.y_lo  <= cfg_wdata[LW-1:0];
            if (cfg_addr == A_YHI)  shadow_q.y_hi  <= cfg_wdata[LW-1:0];
            if (cfg_addr == A_CLO)  shadow_q.c_lo  <= cfg_wdata[LW-1:0];
            if (cfg_addr == A_CHI)  shadow_q.c_hi  <= cfg_wdata[LW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      act_q <= cfg_default();
        else if (commit) act_q <= shadow_q;
    end

    assign act_cfg = act_q;

    assert_hold_between_frames_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_q));

    assert_write_stages_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (state_q == CFG_STAGED));

    assert_strobe_syncs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_STAGED && frame_start && !wr_hit) |=> (state_q == CFG_SYNCED && act_q == $past(shadow_q)));

    assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > A_CHI) |=> $stable(shadow_q));
endmodule

// File: rtl/pix_csc_prep.sv
module pix_csc_prep
    import pix_csc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  csc_cfg_t             cfg,
    input  logic                 in_valid,
    input  logic                 in_rgb,
    input  logic [DW-1:0]        in_pix [NCH],
    output logic                 s1_valid,
    output logic                 s1_rgb,
    output logic [DW-1:0]        s1_raw [NCH],
    output logic signed [MW-1:0] s1_op  [NCH]
);
    logic signed [MW-1:0] op_d [NCH];

    // luma: window, then black-level removal
    assign op_d[0] = clampv(MW'(in_pix[0]), sx(cfg.y_lo), sx(cfg.y_hi)) - sx(cfg.y_off);

    // chroma: re-centre on zero, then window
    for (genvar c = 1; c < NCH; c++) begin : g_chroma
        assign op_d[c] = clampv(MW'(in_pix[c]) - MW'(CHROMA_MID), sx(cfg.c_lo), sx(cfg.c_hi));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_rgb   <= 1'b0;
            for (int c = 0; c < NCH; c++) begin
                s1_raw[c] <= '0;
                s1_op[c]  <= '0;
            end
        end else begin
            s1_valid <= in_valid;
            s1_rgb   <= in_rgb;
            for (int c = 0; c < NCH; c++) begin
                s1_raw[c] <= in_pix[c];
                s1_op[c]  <= op_d[c];
            end
        end
    end

    assert_chroma_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_rgb && $stable(cfg) && sx(cfg.c_lo) <= sx(cfg.c_hi))
        |-> (s1_op[1] >= sx(cfg.c_lo) && s1_op[1] <= sx(cfg.c_hi)
          && s1_op[2] >= sx(cfg.c_lo) && s1_op[2] <= sx(cfg.c_hi)));
endmodule

// File: rtl/pix_csc_mac.sv
module pix_csc_mac
    import pix_csc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  csc_cfg_t             cfg,
    input  logic                 s1_valid,
    input  logic                 s1_rgb,
    input  logic [DW-1:0]        s1_raw [NCH],
    input  logic signed [MW-1:0] s1_op  [NCH],
    output logic                 out_valid,
    output logic                 out_rgb,
    output logic [DW-1:0]        out_pix [NCH]
);
    logic                 s2_valid, s2_rgb;
    logic [DW-1:0]        s2_raw [NCH];
    logic signed [PW-1:0] prod_q [NCH][NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_rgb   <= 1'b0;
            for (int c = 0; c < NCH; c++) s2_raw[c] <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_rgb   <= s1_rgb;
            for (int c = 0; c < NCH; c++) s2_raw[c] <= s1_raw[c];
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_row
        logic signed [SW-1:0] sum;
        logic signed [SW-1:0] shifted;
        logic [DW-1:0]        sat;

        for (genvar k = 0; k < NCH; k++) begin : g_term
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prod_q[ch][k] <= '0;
                else        prod_q[ch][k] <= PW'($signed(cfg.coef[ch*NCH+k])) * PW'(s1_op[k]);
            end
        end

        always_comb begin
            sum = SW'(RND);
            for (int k = 0; k < NCH; k++) sum = sum + SW'(prod_q[ch][k]);
            shifted = sum >>> FRAC;
            if (shifted < 0)                 sat = '0;
            else if (shifted > SW'(PIX_MAX)) sat = DW'(PIX_MAX);
            else                             sat = shifted[DW-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_pix[ch] <= '0;
            else        out_pix[ch] <= s2_rgb ? s2_raw[ch] : sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            out_rgb   <= s2_rgb;
        end
    end

    assert_stage_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_rgb) |=> (out_rgb && out_pix[0] == $past(s2_raw[0])
            && out_pix[1] == $past(s2_raw[1]) && out_pix[2] == $past(s2_raw[2])));
endmodule

// File: rtl/pix_csc_top.sv
module pix_csc_top
    import pix_csc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          frame_start,
    input  logic          in_valid,
    input  logic          in_is_rgb,
    input  logic [DW-1:0] in_c0,
    input  logic [DW-1:0] in_c1,
    input  logic [DW-1:0] in_c2,
    output logic          out_valid,
    output logic          out_is_rgb,
    output logic [DW-1:0] out_r,
    output logic [DW-1:0] out_g,
    output logic [DW-1:0] out_b
);
    csc_cfg_t             cfg;
    logic [DW-1:0]        pix_in  [NCH];
    logic [DW-1:0]        pix_out [NCH];
    logic                 s1_valid, s1_rgb;
    logic [DW-1:0]        s1_raw [NCH];
    logic signed [MW-1:0] s1_op  [NCH];

    assign pix_in[0] = in_c0;
    assign pix_in[1] = in_c1;
    assign pix_in[2] = in_c2;

    pix_csc_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .frame_start (frame_start),
        .act_cfg     (cfg)
    );

    pix_csc_prep u_prep (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .in_valid (in_valid),
        .in_rgb   (in_is_rgb),
        .in_pix   (pix_in),
        .s1_valid (s1_valid),
        .s1_rgb   (s1_rgb),
        .s1_raw   (s1_raw),
        .s1_op    (s1_op)
    );

    pix_csc_mac u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .s1_valid  (s1_valid),
        .s1_rgb    (s1_rgb),
        .s1_raw    (s1_raw),
        .s1_op     (s1_op),
        .out_valid (out_valid),
        .out_rgb   (out_is_rgb),
        .out_pix   (pix_out)
    );

    assign out_r = pix_out[0];
    assign out_g = pix_out[1];
    assign out_b = pix_out[2];

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    assert_idle_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    assert_port_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_rgb) |-> ##3 (out_is_rgb && out_r == $past(in_c0, 3)
            && out_g == $past(in_c1, 3) && out_b == $past(in_c2, 3)));
endmodule

// File: tb/pix_csc_top_tb_top.sv
`timescale 1ns/1ps
module pix_csc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_is_rgb = 1'b0;
    logic [9:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic        out_valid, out_is_rgb;
    logic [9:0]  out_r, out_g, out_b;

    pix_csc_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_is_rgb(in_is_rgb), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_is_rgb(out_is_rgb),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int dflt [14] = '{4769, 0, 6537, 4769, -1605, -3330, 4769, 8263, 0, 64, 64, 940, -448, 448};
    int cur [14], pend [14];

    // stream buffers
    int    ns = 0;
    bit    sv [32], srgb [32];
    int    sa [32], sb [32], sc [32], er [32], eg [32], eb [32];
    string stag [32];

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    task automatic model(input int y, input int cb, input int cr, output int r, output int g, output int b);
        int op [3];
        int res [3];
        op[0] = clampi(y, cur[10], cur[11]) - cur[9];
        op[1] = clampi(cb - 512, cur[12], cur[13]);
        op[2] = clampi(cr - 512, cur[12], cur[13]);
        for (int ch = 0; ch < 3; ch++) begin
            int acc;
            acc = cur[ch*3]*op[0] + cur[ch*3+1]*op[1] + cur[ch*3+2]*op[2] + 2048;
            acc = acc >>> 12;
            res[ch] = clampi(acc, 0, 1023);
        end
        r = res[0]; g = res[1]; b = res[2];
    endtask

    task automatic push(input bit v, input bit rgb, input int a, input int b, input int c, input string tag);
        sv[ns] = v; srgb[ns] = rgb; sa[ns] = a; sb[ns] = b; sc[ns] = c; stag[ns] = tag;
        if (rgb) begin
            er[ns] = a; eg[ns] = b; eb[ns] = c;
        end else begin
            model(a, b, c, er[ns], eg[ns], eb[ns]);
        end
        ns++;
    endtask

    task automatic run_stream();
        for (int j = 0; j < ns + 3; j++) begin
            @(negedge clk);
            if (j >= 3) begin
                int p;
                p = j - 3;
                chk({stag[p], " valid"}, int'(out_valid), int'(sv[p]));
                if (sv[p]) begin
                    chk({stag[p], " fmt"}, int'(out_is_rgb), int'(srgb[p]));
                    chk({stag[p], " r"}, int'(out_r), er[p]);
                    chk({stag[p], " g"}, int'(out_g), eg[p]);
                    chk({stag[p], " b"}, int'(out_b), eb[p]);
                end
            end
            if (j < ns) begin
                in_valid = sv[j]; in_is_rgb = srgb[j];
                in_c0 = 10'(sa[j]); in_c1 = 10'(sb[j]); in_c2 = 10'(sc[j]);
            end else begin
                in_valid = 1'b0; in_is_rgb = 1'b0;
            end
        end
        ns = 0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        if (a < 9) begin
            int s;
            s = d & 16'hFFFF;
            if (s >= 32768) s -= 65536;
            pend[a] = s;
        end else if (a < 14) begin
            int s;
            s = d & 11'h7FF;
            if (s >= 1024) s -= 2048;
            pend[a] = s;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        cur = pend;
    endtask

    task automatic restore_defaults();
        for (int a = 0; a < 14; a++) wr(a, dflt[a]);
        frame();
    endtask

    task automatic t_reset();
        chk("R6 valid in reset", int'(out_valid), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 valid after reset", int'(out_valid), 0);
        // R1: default settings give limited to full range conversion
        push(1, 0, 64, 512, 512, "R1 black");
        push(1, 0, 940, 512, 512, "R1 white");
        push(1, 0, 300, 700, 200, "R1 colour");
        run_stream();
        push(1, 0, 64, 512, 512, "R1 black literal");
        er[0] = 0; eg[0] = 0; eb[0] = 0;
        run_stream();
    endtask

    task automatic t_luma_clamp();
        push(1, 0, 0, 512, 512, "R3 luma below window");
        push(1, 0, 1023, 512, 512, "R3 luma above window");
        push(1, 0, 500, 512, 512, "R3 luma inside window");
        run_stream();
        // luma 0 must behave as luma 64 -> black
        push(1, 0, 0, 512, 512, "R3 luma floor literal");
        er[0] = 0; eg[0] = 0; eb[0] = 0;
        run_stream();
    endtask

    task automatic t_chroma_clamp();
        push(1, 0, 500, 0, 1023, "R2 chroma extremes");
        push(1, 0, 500, 60, 970, "R2 chroma past window");
        push(1, 0, 500, 300, 800, "R2 chroma inside window");
        run_stream();
    endtask

    task automatic t_saturate();
        push(1, 0, 940, 512, 1023, "R4 red ceiling");
        push(1, 0, 64, 512, 0, "R4 red floor");
        run_stream();
        push(1, 0, 940, 512, 1023, "R4 red ceiling literal");
        push(1, 0, 64, 512, 0, "R4 red floor literal");
        er[0] = 1023; er[1] = 0;
        run_stream();
    endtask

    task automatic t_bypass();
        for (int a = 0; a < 9; a++) wr(a, 0);
        wr(9, 500); wr(10, 900); wr(11, 100); wr(12, 300); wr(13, -300);
        frame();
        push(1, 1, 1023, 0, 777, "R5 rgb bypass a");
        push(1, 1, 5, 512, 1000, "R5 rgb bypass b");
        push(1, 0, 700, 200, 900, "R5 ycc with odd settings");
        run_stream();
        restore_defaults();
    endtask

    task automatic t_stream();
        push(1, 0, 200, 400, 600, "R6 s0");
        push(1, 1, 11, 22, 33, "R6 s1");
        push(0, 0, 0, 0, 0, "R6 gap");
        push(1, 0, 800, 100, 900, "R6 s3");
        push(1, 1, 1000, 900, 800, "R6 s4");
        push(1, 0, 64, 1023, 512, "R6 s5");
        push(0, 1, 3, 3, 3, "R6 gap rgb");
        push(1, 0, 940, 0, 0, "R6 s7");
        run_stream();
    endtask

    task automatic t_staged();
        wr(0, 8192);
        push(1, 0, 600, 512, 512, "R7 before strobe old settings");
        run_stream();
        // bench model still holds the old settings here
        frame();
        push(1, 0, 600, 512, 512, "R7 after strobe new settings");
        run_stream();
        restore_defaults();
    endtask

    task automatic t_ignored();
        wr(14, 16'hFFFF);
        wr(15, 16'h8000);
        frame();
        push(1, 0, 300, 700, 200, "R8 unmapped writes ignored");
        push(1, 0, 940, 512, 512, "R8 unmapped writes ignored white");
        run_stream();
    endtask

    initial begin
        cur = dflt;
        pend = dflt;
        t_reset();
        t_luma_clamp();
        t_chroma_clamp();
        t_saturate();
        t_bypass();
        t_stream();
        t_staged();
        t_ignored();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule